// File: doc/BRIEF.md
# PCI Type-0 Configuration Header with Base Address Sizing

This block is the register file behind the standard 64-byte type-0 configuration header of a PCI target. A configuration master presents one access per cycle: a byte offset, an access width in bytes, a read/write flag and write data. One cycle later the block answers with a response strobe, zero-extended read data and two error flags. The flags report an illegal width and an offset inside the device-specific region.

The writable state is small. It holds the command and status halfwords, the cache-line-size and interrupt-line bytes, and six base address registers (BARs). Each BAR is configured per instance: it can be present or absent, and it has an I/O or memory type and a power-of-two window size. Writing all ones to a BAR starts size discovery: the register then reads back the address mask of its window. Any other value is kept as a base address. The low type bits of a BAR can never be written. The vendor and device identifiers are constant parameters. Every other header location reads as zero.

Top module: `cfg_header`

## Requirements
- R1: After reset, command, status, cache line size and interrupt line read zero, each present BAR reads only its type bits (1 for I/O, 0 for memory), and the response strobe and both error flags are low.
- R2: Access widths other than 1, 2 and 4 bytes set the size error flag in the response cycle, return zero read data and change no register.
- R3: Offsets of 0x40 and above set the region error flag in the response cycle, return zero read data and change no register.
- R4: One-byte writes take effect only at 0x0C (cache line size) and 0x3C (interrupt line); at any other offset they are ignored.
- R5: Two-byte writes take effect only at 0x04 (command) and 0x06 (status); at any other offset they are ignored.
- R6: Four-byte writes take effect only at the word-aligned offsets 0x10 to 0x24, with BAR index (offset − 0x10) >> 2; every other four-byte write, including one to the identifier word at 0x00, is ignored.
- R7: A four-byte write of 0xFFFFFFFF to a present BAR makes it read ~(size − 1) with the read-only low bits cleared, ORed with its type bits.
- R8: Any other four-byte value written to a present BAR is stored with its low two bits (I/O BAR) or low four bits (memory BAR) replaced by the type bits.
- R9: An absent BAR reads zero and ignores writes.
- R10: A read returns the header bytes from the offset upward, little-endian: byte offset+k appears at data bits 8k+7..8k. Only as many bytes as the access width are returned, stopping at the end of the aligned word, and the result is zero-extended to 32 bits.
- R11: The word at offset 0x00 reads {DEVICE_ID, VENDOR_ID}.
- R12: Each accepted access produces the response strobe exactly one cycle later; an idle cycle produces no strobe and no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 3 | Access width in bytes |
| acc_offset | input | 8 | Byte offset into configuration space |
| acc_wdata | input | 32 | Write data, right-aligned to the access width |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_rdata | output | 32 | Zero-extended read data (zero for writes and errors) |
| err_size | output | 1 | Previous access had an illegal width |
| err_region | output | 1 | Previous access hit the device-specific region |

## Verification
The assertions assume that reset lasts at least one clock edge and that a size or region error is judged on the access itself, with no history. They also assume every configured BAR window is at least 16 bytes, so that the size mask never reaches into the type bits. The stimulus respects this. Every BAR in the bench has a size of 16 bytes or more. Random accesses mix legal and illegal widths with offsets that favour the named registers, every BAR word, unaligned BAR offsets and the device-specific region. All-ones data appears often enough that sizing and base writes interleave on the same BAR.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int          CFG_OFF_W    = 8;
    localparam int          NUM_BAR      = 6;
    localparam int          BAR_LOG2_W   = 6;
    localparam logic [7:0]  OFF_COMMAND  = 8'h04;
    localparam logic [7:0]  OFF_STATUS   = 8'h06;
    localparam logic [7:0]  OFF_CLSIZE   = 8'h0C;
    localparam logic [7:0]  OFF_BAR_BASE = 8'h10;
    localparam logic [7:0]  OFF_INTLINE  = 8'h3C;
    localparam logic [7:0]  OFF_DEVSPEC  = 8'h40;

    typedef struct packed {
        logic               size_ok;
        logic               region_ok;
        logic               wr_cmd;
        logic               wr_sts;
        logic               wr_cls;
        logic               wr_il;
        logic [NUM_BAR-1:0] wr_bar;
    } cfg_dec_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    // read-only low bits of a BAR: two for I/O, four for memory
    function automatic logic [31:0] bar_low_mask(input logic is_io);
        return is_io ? 32'h0000_0003 : 32'h0000_000F;
    endfunction

    function automatic logic [31:0] bar_type_bits(input logic is_io);
        return is_io ? 32'h0000_0001 : 32'h0000_0000;
    endfunction

    function automatic logic [31:0] window_mask(input int unsigned log2sz);
        return ~((32'h1 << log2sz) - 32'h1);
    endfunction

    function automatic logic [31:0] width_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_pkg::*;
(
    input  logic                 valid,
    input  logic                 write,
    input  logic [2:0]           size,
    input  logic [CFG_OFF_W-1:0] offset,
    output cfg_dec_t             dec
);

    logic wr_ok;

    always_comb begin
        dec           = '0;
        dec.size_ok   = size_legal(size);
        dec.region_ok = offset < OFF_DEVSPEC;
        wr_ok         = valid && write && dec.size_ok && dec.region_ok;
        dec.wr_cls    = wr_ok && (size == 3'd1) && (offset == OFF_CLSIZE);
        dec.wr_il     = wr_ok && (size == 3'd1) && (offset == OFF_INTLINE);
        dec.wr_cmd    = wr_ok && (size == 3'd2) && (offset == OFF_COMMAND);
        dec.wr_sts    = wr_ok && (size == 3'd2) && (offset == OFF_STATUS);
        for (int i = 0; i < NUM_BAR; i++) begin
            dec.wr_bar[i] = wr_ok && (size == 3'd4) &&
                            (offset == CFG_OFF_W'(int'(OFF_BAR_BASE) + 4 * i));
        end
    end

endmodule

// File: rtl/cfg_bar.sv
module cfg_bar
    import cfg_pkg::*;
#(
    parameter bit          ENABLE    = 1'b1,
    parameter bit          IS_IO     = 1'b0,
    parameter int unsigned SIZE_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] value
);

    localparam logic [31:0] LOW_M  = bar_low_mask(IS_IO);
    localparam logic [31:0] TYPE_B = bar_type_bits(IS_IO);
    localparam logic [31:0] WIN_M  = window_mask(SIZE_LOG2);

    generate
        if (ENABLE) begin : g_present
            logic [31:0] bar_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    bar_q <= TYPE_B;
                end else if (wr_en) begin
                    if (&wdata) bar_q <= (WIN_M & ~LOW_M) | TYPE_B;
                    else        bar_q <= (wdata & ~LOW_M) | TYPE_B;
                end
            end

            assign value = bar_q;

            // the read-only type bits survive every write (R8)
            p_type_kept_r8: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> ((value & LOW_M) == TYPE_B));

            // a sizing write leaves the bits inside the window cleared (R7)
            p_size_window_r7: assert property (@(posedge clk) disable iff (rst)
                (wr_en && (&wdata)) |=> ((value & ~WIN_M & ~LOW_M) == 32'h0));

            // a non-sizing write keeps the upper data bits as written (R8)
            p_base_kept_r8: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !(&wdata)) |=> ((value & ~LOW_M) == ($past(wdata) & ~LOW_M)));
        end else begin : g_absent
            logic unused_bar_in;
            assign unused_bar_in = ^{clk, rst, wr_en, wdata};
            assign value = '0;
        end
    endgenerate

endmodule

// File: rtl/cfg_rdmux.sv
module cfg_rdmux
    import cfg_pkg::*;
(
    input  logic [31:0] word,
    input  logic [1:0]  byte_off,
    input  logic [2:0]  size,
    input  logic        rd_ok,
    output logic [31:0] data
);

    logic [31:0] shifted;

    always_comb begin
        shifted = word >> {byte_off, 3'b000};
        data    = rd_ok ? (shifted & width_mask(size)) : 32'h0;
    end

endmodule

// File: rtl/cfg_header.sv
module cfg_header
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h0C0D,
    parameter logic [NUM_BAR-1:0] BAR_EN = 6'b110111,
    parameter logic [NUM_BAR-1:0] BAR_IO = 6'b010010,
    parameter logic [NUM_BAR*BAR_LOG2_W-1:0] BAR_LOG2 =
        {6'd16, 6'd4, 6'd0, 6'd20, 6'd8, 6'd12}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [2:0]  acc_size,
    input  logic [7:0]  acc_offset,
    input  logic [31:0] acc_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        err_size,
    output logic        err_region
);

    cfg_dec_t                  dec;
    logic [15:0]               cmd_q;
    logic [15:0]               sts_q;
    logic [7:0]                cls_q;
    logic [7:0]                il_q;
    logic [NUM_BAR-1:0][31:0]  bar_val;
    logic [31:0]               hdr_word;
    logic [31:0]               rd_data;
    logic                      rd_ok;

    cfg_decode u_dec (
        .valid  (acc_valid),
        .write  (acc_write),
        .size   (acc_size),
        .offset (acc_offset),
        .dec    (dec)
    );

    generate
        for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
            cfg_bar #(
                .ENABLE    (BAR_EN[i]),
                .IS_IO     (BAR_IO[i]),
                .SIZE_LOG2 (int'(BAR_LOG2[i*BAR_LOG2_W +: BAR_LOG2_W]))
            ) u_bar (
                .clk   (clk),
                .rst   (rst),
                .wr_en (dec.wr_bar[i]),
                .wdata (acc_wdata),
                .value (bar_val[i])
            );
        end
    endgenerate

    always_comb begin
        case (acc_offset[5:2])
            4'd0:    hdr_word = {DEVICE_ID, VENDOR_ID};
            4'd1:    hdr_word = {sts_q, cmd_q};
            4'd3:    hdr_word = {24'h0, cls_q};
            4'd4:    hdr_word = bar_val[0];
            4'd5:    hdr_word = bar_val[1];
            4'd6:    hdr_word = bar_val[2];
            4'd7:    hdr_word = bar_val[3];
            4'd8:    hdr_word = bar_val[4];
            4'd9:    hdr_word = bar_val[5];
            4'd15:   hdr_word = {24'h0, il_q};
            default: hdr_word = 32'h0;
        endcase
    end

    assign rd_ok = acc_valid && !acc_write && dec.size_ok && dec.region_ok;

    cfg_rdmux u_rd (
        .word     (hdr_word),
        .byte_off (acc_offset[1:0]),
        .size     (acc_size),
        .rd_ok    (rd_ok),
        .data     (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            sts_q      <= '0;
            cls_q      <= '0;
            il_q       <= '0;
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            err_size   <= 1'b0;
            err_region <= 1'b0;
        end else begin
            if (dec.wr_cmd) cmd_q <= acc_wdata[15:0];
            if (dec.wr_sts) sts_q <= acc_wdata[15:0];
            if (dec.wr_cls) cls_q <= acc_wdata[7:0];
            if (dec.wr_il)  il_q  <= acc_wdata[7:0];
            rsp_valid  <= acc_valid;
            rsp_rdata  <= rd_data;
            err_size   <= acc_valid && !dec.size_ok;
            err_region <= acc_valid && !dec.region_ok;
        end
    end

    // response one cycle after each access (R12)
    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!rsp_valid && !err_size && !err_region));

    // illegal width: flag, zero data, no register change (R2)
    p_bad_size_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !size_legal(acc_size)) |=>
        (err_size && rsp_rdata == 32'h0 && $stable(cmd_q) && $stable(sts_q) &&
         $stable(cls_q) && $stable(il_q) && $stable(bar_val)));

    // device-specific region: flag, zero data, no register change (R3)
    p_bad_region_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_offset >= 8'h40) |=>
        (err_region && rsp_rdata == 32'h0 && $stable(cmd_q) && $stable(sts_q) &&
         $stable(cls_q) && $stable(il_q) && $stable(bar_val)));

    // byte writes never reach halfword or BAR state (R4)
    p_byte_scope_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size == 3'd1) |=>
        ($stable(cmd_q) && $stable(sts_q) && $stable(bar_val)));

    // halfword writes never reach byte or BAR state (R5)
    p_half_scope_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size == 3'd2) |=>
        ($stable(cls_q) && $stable(il_q) && $stable(bar_val)));

    // only word writes can touch a BAR (R6)
    p_bar_word_only_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_size != 3'd4) |=> $stable(bar_val));

    // writes return zero data
    p_write_no_data_r10: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> (rsp_rdata == 32'h0));

endmodule

// File: tb/cfg_header_test.sv
`timescale 1ns/1ps
module cfg_header_test;

    localparam logic [15:0] T_VEN = 16'h1A2B;
    localparam logic [15:0] T_DEV = 16'h0C0D;
    localparam logic [5:0]  T_EN  = 6'b110111;
    localparam logic [5:0]  T_IO  = 6'b010010;
    localparam logic [35:0] T_LG  = {6'd16, 6'd4, 6'd0, 6'd20, 6'd8, 6'd12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [2:0]  acc_size = 3'd0;
    logic [7:0]  acc_offset = 8'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err_size;
    logic        err_region;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    logic [15:0] m_cmd, m_sts;
    logic [7:0]  m_cls, m_il;
    logic [31:0] m_bar [6];
    logic [31:0] last_rd;

    always #2.5 clk = ~clk;

    cfg_header #(
        .VENDOR_ID (T_VEN),
        .DEVICE_ID (T_DEV),
        .BAR_EN    (T_EN),
        .BAR_IO    (T_IO),
        .BAR_LOG2  (T_LG)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_size   (acc_size),
        .acc_offset (acc_offset),
        .acc_wdata  (acc_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .err_size   (err_size),
        .err_region (err_region)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] low_of(input int i);
        return T_IO[i] ? 32'h3 : 32'hF;
    endfunction

    function automatic logic [31:0] type_of(input int i);
        return T_IO[i] ? 32'h1 : 32'h0;
    endfunction

    function automatic logic [31:0] m_word(input logic [3:0] idx);
        case (idx)
            4'd0:  return {T_DEV, T_VEN};
            4'd1:  return {m_sts, m_cmd};
            4'd3:  return {24'h0, m_cls};
            4'd15: return {24'h0, m_il};
            default:
                if (idx >= 4'd4 && idx <= 4'd9) return m_bar[int'(idx) - 4];
                else return 32'h0;
        endcase
    endfunction

    function automatic bit legal(input logic [2:0] s);
        return s == 3'd1 || s == 3'd2 || s == 3'd4;
    endfunction

    task automatic model_reset();
        m_cmd = 0; m_sts = 0; m_cls = 0; m_il = 0;
        for (int i = 0; i < 6; i++) m_bar[i] = T_EN[i] ? type_of(i) : 32'h0;
    endtask

    task automatic model_write(input logic [2:0] s, input logic [7:0] o,
                               input logic [31:0] d);
        if (!legal(s) || o >= 8'h40) return;
        if (s == 3'd1) begin
            if (o == 8'h0C) m_cls = d[7:0];
            if (o == 8'h3C) m_il  = d[7:0];
        end else if (s == 3'd2) begin
            if (o == 8'h04) m_cmd = d[15:0];
            if (o == 8'h06) m_sts = d[15:0];
        end else if (o >= 8'h10 && o <= 8'h24 && o[1:0] == 2'b00) begin
            int i;
            i = int'(o - 8'h10) >> 2;
            if (T_EN[i]) begin
                logic [31:0] v;
                if (d == 32'hFFFF_FFFF)
                    v = ~((32'h1 << int'(T_LG[i*6 +: 6])) - 32'h1);
                else
                    v = d;
                m_bar[i] = (v & ~low_of(i)) | type_of(i);
            end
        end
    endtask

    // one access; checks strobe, error flags and read data against the model
    task automatic access(input bit w, input logic [2:0] s, input logic [7:0] o,
                          input logic [31:0] d, input string tag);
        logic [31:0] exp;
        bit bad_s, bad_r;
        bad_s = !legal(s);
        bad_r = o >= 8'h40;
        exp = 32'h0;
        if (!w && !bad_s && !bad_r) begin
            logic [31:0] m;
            m = (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
            exp = (m_word(o[5:2]) >> (8 * int'(o[1:0]))) & m;
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_size = s; acc_offset = o; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        if (w) model_write(s, o, d);
        check(rsp_valid === 1'b1, "R12 strobe", {31'h0, rsp_valid}, 32'h1);
        check(err_size === bad_s, "R2 size flag", {31'h0, err_size}, {31'h0, bad_s});
        check(err_region === bad_r, "R3 region flag", {31'h0, err_region}, {31'h0, bad_r});
        check(rsp_rdata === exp, tag, rsp_rdata, exp);
        last_rd = rsp_rdata;
    endtask

    task automatic rd(input logic [2:0] s, input logic [7:0] o, input string tag);
        access(1'b0, s, o, 32'h0, tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] o, input logic [31:0] d);
        access(1'b1, s, o, d, "write data zero");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state and R12 idle behaviour
        check(rsp_valid === 1'b0 && err_size === 1'b0 && err_region === 1'b0,
              "R1 outputs after reset", {29'h0, rsp_valid, err_size, err_region}, 32'h0);
        rd(3'd4, 8'h04, "R1 command/status reset");
        check(last_rd === 32'h0, "R1 cmd/sts zero", last_rd, 32'h0);
        rd(3'd4, 8'h10, "R1 memory BAR reset");
        check(last_rd === 32'h0, "R1 bar0 type", last_rd, 32'h0);
        rd(3'd4, 8'h14, "R1 io BAR reset");
        check(last_rd === 32'h1, "R1 bar1 type", last_rd, 32'h1);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R12 idle no strobe", {31'h0, rsp_valid}, 32'h0);

        // R11 identity and R6 read-only words
        rd(3'd4, 8'h00, "R11 identity");
        check(last_rd === {T_DEV, T_VEN}, "R11 id literal", last_rd, {T_DEV, T_VEN});
        wr(3'd4, 8'h00, 32'h1234_5678);
        rd(3'd4, 8'h00, "R6 identity unchanged");
        check(last_rd === {T_DEV, T_VEN}, "R6 id literal", last_rd, {T_DEV, T_VEN});

        // R7 sizing
        wr(3'd4, 8'h10, 32'hFFFF_FFFF);
        rd(3'd4, 8'h10, "R7 bar0 size");
        check(last_rd === 32'hFFFF_F000, "R7 bar0 literal", last_rd, 32'hFFFF_F000);
        wr(3'd4, 8'h14, 32'hFFFF_FFFF);
        rd(3'd4, 8'h14, "R7 bar1 size");
        check(last_rd === 32'hFFFF_FF01, "R7 bar1 literal", last_rd, 32'hFFFF_FF01);
        wr(3'd4, 8'h20, 32'hFFFF_FFFF);
        rd(3'd4, 8'h20, "R7 bar4 size");
        check(last_rd === 32'hFFFF_FFF1, "R7 bar4 literal", last_rd, 32'hFFFF_FFF1);
        wr(3'd4, 8'h18, 32'hFFFF_FFFF);
        rd(3'd4, 8'h18, "R7 bar2 size");
        check(last_rd === 32'hFFF0_0000, "R7 bar2 literal", last_rd, 32'hFFF0_0000);

        // R8 base addresses keep type bits
        wr(3'd4, 8'h10, 32'hABCD_123F);
        rd(3'd4, 8'h10, "R8 bar0 base");
        check(last_rd === 32'hABCD_1230, "R8 bar0 literal", last_rd, 32'hABCD_1230);
        wr(3'd4, 8'h14, 32'h0000_C002);
        rd(3'd4, 8'h14, "R8 bar1 base");
        check(last_rd === 32'h0000_C001, "R8 bar1 literal", last_rd, 32'h0000_C001);

        // R9 absent BAR
        wr(3'd4, 8'h1C, 32'hFFFF_FFFF);
        rd(3'd4, 8'h1C, "R9 absent bar");
        check(last_rd === 32'h0, "R9 literal", last_rd, 32'h0);

        // R6 unaligned word write ignored
        wr(3'd4, 8'h11, 32'h5555_5555);
        rd(3'd4, 8'h10, "R6 unaligned ignored");
        check(last_rd === 32'hABCD_1230, "R6 literal", last_rd, 32'hABCD_1230);

        // R4 byte writes
        wr(3'd1, 8'h0C, 32'h0000_0010);
        wr(3'd1, 8'h3C, 32'h0000_000B);
        wr(3'd1, 8'h04, 32'h0000_00FF);
        rd(3'd1, 8'h0C, "R4 cache line");
        check(last_rd === 32'h10, "R4 cls literal", last_rd, 32'h10);
        rd(3'd1, 8'h3C, "R4 int line");
        check(last_rd === 32'h0B, "R4 il literal", last_rd, 32'h0B);
        rd(3'd2, 8'h04, "R4 command untouched");
        check(last_rd === 32'h0, "R4 cmd literal", last_rd, 32'h0);

        // R5 halfword writes
        wr(3'd2, 8'h04, 32'h0000_0147);
        wr(3'd2, 8'h06, 32'h0000_1234);
        wr(3'd2, 8'h0C, 32'h0000_BEEF);
        rd(3'd4, 8'h04, "R5 command/status");
        check(last_rd === 32'h1234_0147, "R5 literal", last_rd, 32'h1234_0147);
        rd(3'd1, 8'h0C, "R5 cls untouched");
        check(last_rd === 32'h10, "R5 cls literal", last_rd, 32'h10);

        // R10 little-endian partial reads
        rd(3'd1, 8'h05, "R10 byte");
        check(last_rd === 32'h01, "R10 byte literal", last_rd, 32'h01);
        rd(3'd2, 8'h05, "R10 half");
        check(last_rd === 32'h3401, "R10 half literal", last_rd, 32'h3401);
        rd(3'd2, 8'h07, "R10 half at word end");
        check(last_rd === 32'h12, "R10 end literal", last_rd, 32'h12);

        // R2 illegal widths, R3 device-specific region
        wr(3'd3, 8'h04, 32'h0000_FFFF);
        rd(3'd0, 8'h04, "R2 zero width read");
        rd(3'd2, 8'h04, "R2 command unchanged");
        check(last_rd === 32'h0147, "R2 literal", last_rd, 32'h0147);
        wr(3'd4, 8'h40, 32'hDEAD_BEEF);
        rd(3'd4, 8'h48, "R3 region read");
        rd(3'd1, 8'h3C, "R3 int line unchanged");
        check(last_rd === 32'h0B, "R3 literal", last_rd, 32'h0B);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0]  o;
            logic [2:0]  s;
            logic [31:0] d;
            bit          w;
            int unsigned r;
            r = $urandom % 16;
            case (r)
                0: o = 8'h04; 1: o = 8'h06; 2: o = 8'h0C; 3: o = 8'h3C;
                4: o = 8'h00; 5: o = 8'h40 + 8'($urandom % 16);
                6, 7, 8: o = 8'h10 + 8'(4 * ($urandom % 6));
                9: o = 8'h10 + 8'($urandom % 24);
                default: o = 8'($urandom % 80);
            endcase
            r = $urandom % 8;
            case (r)
                0, 1, 2: s = 3'd4;
                3, 4: s = 3'd1;
                5, 6: s = 3'd2;
                default: s = 3'($urandom % 8);
            endcase
            w = ($urandom % 2) == 1;
            d = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            if (w) access(1'b1, s, o, d, "write data zero");
            else if (o >= 8'h10 && o < 8'h28) access(1'b0, s, o, 32'h0, "R8 random BAR read");
            else access(1'b0, s, o, 32'h0, "R10 random read");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule